// File: doc/BRIEF.md
# Majority-Vote Register Read Filter

This block sits between a requester and a register source that sometimes returns a wrong value. A read through the filter is not a single access. The block reads the same address `SAMPLES` times in a row (100 by default) and stores every sample in a local buffer. It then walks the buffer in capture order and keeps a table of the distinct values it has seen, with an occurrence count for each one. The value that occurred most often is returned.

Counting stops early once one value has occurred in more than half of the samples, because no other value can then catch up. If two values reach the same top count, the value that reached that count first is kept. A later value replaces the current best only when its count is strictly higher. The table is emptied at the start of every request, so earlier reads do not affect the result.

The source is expected to answer in the same cycle as the strobe: `smp_data_i` is captured on the rising edge where `smp_stb_o` is high. The result comes back on `result_o` together with a one-cycle `done_o` pulse. A new request is accepted only while the block is idle.

Top module: `reg_vote_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy_o`, `done_o` and `smp_stb_o` are low and `result_o` is zero.
- R2: An accepted request drives `smp_stb_o` high for exactly `SAMPLES` consecutive cycles. During those cycles `smp_addr_o` holds the `addr_i` value captured on the accepting edge.
- R3: Counting begins only after the last sample has been captured. Samples are counted in the order in which they were captured.
- R4: The result is the value with the highest occurrence count. When counts tie, the value that reached the top count first wins.
- R5: Counting stops at the first sample whose value count exceeds `SAMPLES/2`. If no count does, counting stops after the last sample. Let k be the number of samples counted. `done_o` is then high in the cycle after the (`SAMPLES`+k)-th rising edge that follows the accepting edge: 151 edges when all samples are equal, 200 edges when no value gets a majority.
- R6: `done_o` is high for exactly one cycle, and `busy_o` is low in the following cycle. `result_o` changes only together with `done_o` and then keeps its value.
- R7: A request raised while `busy_o` is high is ignored. It does not change the address, the result, the latency, or the number of strobes, and it produces no second `done_o` pulse.
- R8: The value table is cleared at each accepted request, so the counts from an earlier read do not affect a later one.
- R9: When all samples are identical, the result is that value and exactly `SAMPLES/2+1` samples are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a filtered read (taken only while idle) |
| addr_i | input | AW | Register address for the read |
| busy_o | output | 1 | High from the accepting edge through the done cycle |
| smp_stb_o | output | 1 | Sample strobe to the source, one sample per cycle |
| smp_addr_o | output | AW | Address presented to the source |
| smp_data_i | input | DW | Source data, captured on edges where the strobe is high |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| result_o | output | DW | Most frequent sampled value |

## Verification
The checker assumes that reset is held low for at least one rising edge. It also assumes that the block starts each request from idle, so its per-request strobe counter can restart whenever `busy_o` is low. Nothing is assumed about `req_i` or the source data. Requests may arrive at any time, and the mid-capture request in the stimulus deliberately hits the busy window.

The stimulus drives `req_i` and the address only at falling edges. It models the source as a combinational function of the number of strobes seen, so each captured sample is known exactly. Requests are spaced so that each one lands on an idle cycle, except for the intentional busy-time request.

// File: rtl/rvf_pkg.sv
package rvf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_COUNT   = 2'd2,
        ST_DONE    = 2'd3
    } rvf_state_e;

endpackage

// File: rtl/rvf_sample_buf.sv
// Holds the captured samples of one filtered read; asynchronous read port.
module rvf_sample_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 100
) (
    input  logic                     clk_i,
    input  logic                     wr_en_i,
    input  logic [$clog2(DEPTH)-1:0] wr_idx_i,
    input  logic [DW-1:0]            wr_data_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic [DW-1:0]            rd_data_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/rvf_tally.sv
// Distinct-value table with occurrence counters.
// cnt_o gives the count the presented value reaches once it is recorded
// (0 when the value is new and the table is already full).
module rvf_tally #(
    parameter int DW      = 32,
    parameter int ENTRIES = 100,
    parameter int CW      = 7
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          upd_i,
    input  logic [DW-1:0] val_i,
    output logic [CW-1:0] cnt_o
);
    localparam int TW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int FW = $clog2(ENTRIES + 1);

    logic [ENTRIES-1:0] vld_q, vld_d;
    logic [DW-1:0]      val_q [ENTRIES];
    logic [DW-1:0]      val_d [ENTRIES];
    logic [CW-1:0]      cnt_q [ENTRIES];
    logic [CW-1:0]      cnt_d [ENTRIES];
    logic [FW-1:0]      fill_q, fill_d;

    logic [ENTRIES-1:0] hit;
    logic [TW-1:0]      hit_idx;
    logic               any_hit;
    logic               full;

    for (genvar j = 0; j < ENTRIES; j++) begin : g_cmp
        assign hit[j] = vld_q[j] && (val_q[j] == val_i);
    end

    assign any_hit = |hit;
    assign full    = (fill_q == FW'(ENTRIES));

    always_comb begin
        hit_idx = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (hit[j]) begin
                hit_idx = TW'(j);
            end
        end
    end

    always_comb begin
        if (any_hit) begin
            cnt_o = CW'(cnt_q[hit_idx] + 1'b1);
        end else if (!full) begin
            cnt_o = CW'(1);
        end else begin
            cnt_o = '0;
        end
    end

    always_comb begin
        vld_d  = vld_q;
        val_d  = val_q;
        cnt_d  = cnt_q;
        fill_d = fill_q;
        if (clr_i) begin
            vld_d  = '0;
            fill_d = '0;
        end else if (upd_i) begin
            if (any_hit) begin
                cnt_d[hit_idx] = cnt_o;
            end else if (!full) begin
                vld_d[TW'(fill_q)] = 1'b1;
                val_d[TW'(fill_q)] = val_i;
                cnt_d[TW'(fill_q)] = CW'(1);
                fill_d             = fill_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vld_q  <= '0;
            fill_q <= '0;
        end else begin
            vld_q  <= vld_d;
            fill_q <= fill_d;
        end
    end

    always_ff @(posedge clk_i) begin
        val_q <= val_d;
        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/reg_vote_filter.sv
module reg_vote_filter
    import rvf_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 8,
    parameter int SAMPLES = 100,
    parameter int ENTRIES = SAMPLES
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    output logic          busy_o,
    output logic          smp_stb_o,
    output logic [AW-1:0] smp_addr_o,
    input  logic [DW-1:0] smp_data_i,
    output logic          done_o,
    output logic [DW-1:0] result_o
);
    localparam int IW   = $clog2(SAMPLES);
    localparam int CW   = $clog2(SAMPLES + 1);
    localparam int HALF = SAMPLES / 2;
    localparam logic [IW-1:0] LAST = IW'(SAMPLES - 1);

    typedef struct packed {
        rvf_state_e    st;
        logic [IW-1:0] idx;
        logic [AW-1:0] addr;
        logic [DW-1:0] best_val;
        logic [CW-1:0] best_cnt;
        logic [DW-1:0] result;
    } ctl_t;

    ctl_t          q, d;
    logic          buf_we;
    logic [DW-1:0] buf_rd;
    logic          tly_clr;
    logic          tly_upd;
    logic [CW-1:0] tly_cnt;

    rvf_sample_buf #(
        .DW    (DW),
        .DEPTH (SAMPLES)
    ) i_buf (
        .clk_i     (clk_i),
        .wr_en_i   (buf_we),
        .wr_idx_i  (q.idx),
        .wr_data_i (smp_data_i),
        .rd_idx_i  (q.idx),
        .rd_data_o (buf_rd)
    );

    rvf_tally #(
        .DW      (DW),
        .ENTRIES (ENTRIES),
        .CW      (CW)
    ) i_tally (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tly_clr),
        .upd_i  (tly_upd),
        .val_i  (buf_rd),
        .cnt_o  (tly_cnt)
    );

    always_comb begin
        d       = q;
        buf_we  = 1'b0;
        tly_clr = 1'b0;
        tly_upd = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_i) begin
                    d.st       = ST_CAPTURE;
                    d.idx      = '0;
                    d.addr     = addr_i;
                    d.best_val = '0;
                    d.best_cnt = '0;
                    tly_clr    = 1'b1;
                end
            end
            ST_CAPTURE: begin
                buf_we = 1'b1;
                if (q.idx == LAST) begin
                    d.st  = ST_COUNT;
                    d.idx = '0;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_COUNT: begin
                tly_upd = 1'b1;
                if (tly_cnt > q.best_cnt) begin
                    d.best_val = buf_rd;
                    d.best_cnt = tly_cnt;
                end
                if ((q.idx == LAST) || (tly_cnt > CW'(HALF))) begin
                    d.st     = ST_DONE;
                    d.result = d.best_val;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != ST_IDLE);
    assign smp_stb_o  = (q.st == ST_CAPTURE);
    assign smp_addr_o = q.addr;
    assign done_o     = (q.st == ST_DONE);
    assign result_o   = q.result;
endmodule

// File: rtl/rvf_checker.sv
module rvf_checker #(
    parameter int DW      = 32,
    parameter int AW      = 8,
    parameter int SAMPLES = 100
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          busy_o,
    input logic          smp_stb_o,
    input logic [AW-1:0] smp_addr_o,
    input logic          done_o,
    input logic [DW-1:0] result_o
);
    localparam int SW = $clog2(SAMPLES + 2);

    logic [SW-1:0] stb_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stb_cnt_q <= '0;
        end else if (!busy_o) begin
            stb_cnt_q <= '0;
        end else if (smp_stb_o) begin
            stb_cnt_q <= stb_cnt_q + 1'b1;
        end
    end

    AST_STB_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_stb_o |-> busy_o); // R2
    AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_stb_o && $past(smp_stb_o)) |-> $stable(smp_addr_o)); // R2
    AST_STB_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (stb_cnt_q == SW'(SAMPLES))); // R2
    AST_NO_STB_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !smp_stb_o); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R6
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !busy_o); // R6
    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o)); // R6
endmodule

bind reg_vote_filter rvf_checker #(
    .DW      (DW),
    .AW      (AW),
    .SAMPLES (SAMPLES)
) i_rvf_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_o     (busy_o),
    .smp_stb_o  (smp_stb_o),
    .smp_addr_o (smp_addr_o),
    .done_o     (done_o),
    .result_o   (result_o)
);

// File: tb/test_reg_vote_filter.sv
module test_reg_vote_filter;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int N  = 100;

    localparam logic [31:0] VA = 32'h1111_1111;
    localparam logic [31:0] VB = 32'h2222_2222;
    localparam logic [31:0] VC = 32'h3333_3333;
    localparam logic [31:0] VX = 32'h5A5A_0007;
    localparam logic [31:0] VS = 32'hCAFE_0001;

    typedef struct packed {
        logic [2:0]  mode;
        logic [31:0] exp;
        logic [8:0]  lat;
    } vec_t;

    // lat = N + samples counted (R5)
    localparam vec_t VECS [8] = '{
        '{3'd0, VS,          9'd151},  // R9 all identical
        '{3'd1, VA,          9'd200},  // R4 34/33/33
        '{3'd3, VB,          9'd200},  // R4 late majority, stops on last sample
        '{3'd2, VA,          9'd200},  // R4 tie 50/50, R8 after same values
        '{3'd4, 32'd3,       9'd200},  // R4 all distinct, first wins
        '{3'd5, VX,          9'd151},  // R5 early stop
        '{3'd6, VX,          9'd200},  // R4 half X, rest noise
        '{3'd7, VX,          9'd171}   // R5 majority after noise
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          busy, stb, done;
    logic [AW-1:0] smp_addr;
    logic [DW-1:0] smp_data, result;

    int            checks = 0;
    int            fails = 0;
    int            scnt = 0;
    logic [2:0]    pat_mode = '0;

    always #4 clk = ~clk;

    function automatic logic [31:0] pat(input logic [2:0] m, input int i);
        case (m)
            3'd0: return VS;
            3'd1: return (i % 3 == 0) ? VA : ((i % 3 == 1) ? VB : VC);
            3'd2: return (i < 50) ? VA : VB;
            3'd3: return (i < 49) ? VA : VB;
            3'd4: return 32'(i * 7 + 3);
            3'd5: return (i < 60) ? VX : 32'(i);
            3'd6: return (i % 2 == 0) ? VX : (32'h8000_0000 | 32'(i));
            default: return (i < 20) ? (32'h4000_0000 + 32'(i)) : VX;
        endcase
    endfunction

    assign smp_data = pat(pat_mode, scnt);

    always @(posedge clk) begin
        if (req && !busy) scnt <= 0;
        else if (stb) scnt <= scnt + 1;
    end

    reg_vote_filter #(.DW(DW), .AW(AW), .SAMPLES(N)) i_reg_vote_filter (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .req_i      (req),
        .addr_i     (addr),
        .busy_o     (busy),
        .smp_stb_o  (stb),
        .smp_addr_o (smp_addr),
        .smp_data_i (smp_data),
        .done_o     (done),
        .result_o   (result)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic run_one(input logic [2:0] m, input logic [AW-1:0] a, input bit poke,
                           input logic [31:0] exp, input int exp_lat);
        int n = 0;
        bit addr_ok = 1'b1;
        logic [31:0] res;
        repeat (2) @(negedge clk);
        pat_mode = m;
        req  = 1'b1;
        addr = a;
        @(posedge clk);          // accepting edge
        #1 req = 1'b0;
        addr = ~a;
        while (n < 400) begin
            if (stb && smp_addr != a) addr_ok = 1'b0;
            @(posedge clk);
            n++;
            #1;
            if (poke && n == 10) req = 1'b1;
            if (poke && n == 11) req = 1'b0;
            if (done) break;
        end
        res = result;
        check(res == exp, "R4 result", res, exp);
        check(n == exp_lat, "R5 latency", 32'(n), 32'(exp_lat));
        check(addr_ok, "R2 address held", {24'd0, smp_addr}, {24'd0, a});
        check(scnt == N, "R2 strobe count", 32'(scnt), 32'(N));
        @(posedge clk);
        #1;
        check(!done && !busy, "R6 single pulse then idle", {30'd0, done, busy}, 32'd0);
        check(result == res, "R6 result held", result, res);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1;
        check(!busy && !done && !stb, "R1 in reset", {29'd0, busy, done, stb}, 32'd0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(!busy && !done && !stb && result == '0, "R1 after reset",
              {29'd0, busy, done, stb}, 32'd0);

        // vector table (R3 ordering is implied by the tie/late-majority cases)
        for (int v = 0; v < 8; v++) begin
            run_one(VECS[v].mode, AW'(8'h10 + v), 1'b0, VECS[v].exp, int'(VECS[v].lat));
        end

        // R7: request raised mid-capture is ignored
        run_one(3'd1, 8'hA5, 1'b1, VA, 200);
        begin
            bit extra = 1'b0;
            for (int c = 0; c < 300; c++) begin
                @(posedge clk);
                #1;
                if (done || busy) extra = 1'b1;
            end
            check(!extra, "R7 no second read", {31'd0, extra}, 32'd0);
            check(result == VA, "R7 result kept", result, VA);
        end

        // R8: table starts empty again after a majority read of the same values
        run_one(3'd0, 8'h3C, 1'b0, VS, 151);  // R9 again
        run_one(3'd0, 8'h3D, 1'b0, VS, 151);  // R8 would stop at sample 1 if not cleared

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule